// File: doc/BRIEF.md
# Dual-Format Serial Configuration Write Port

This block is a slave-only control port. It lets a host processor load 9-bit configuration registers over a few pins. Every transfer carries one 16-bit control word. The upper seven bits name the target register and the lower nine bits are the value. The block turns each complete word into a one-cycle write strobe, which the register bank beside it consumes. A static format-select input chooses between two framings.

In the latched 3-wire framing, the host drives a data line and a serial clock while a chip-select is low. Raising chip-select commits the word. In the 2-wire framing, the bus behaves like I2C. The host sends a start condition, a 7-bit device address with a direction bit, and then two data bytes. The block acknowledges each byte by pulling the data line low through an open-drain enable. Read requests are not served. The block never drives the clock line.

All pins are brought into the system clock domain through two-flop synchronizers, and edges are found on the synchronized levels. The write strobe has no back-pressure, because the serial host cannot be stalled. The consumer must accept the address and data in the cycle the strobe is high. That is always possible, since strobes are separated by at least one full serial word.

Top module: `ctlport_slave`

## Requirements
- R1: A committed word drives `wr_addr` with word bits 15..9 and `wr_data` with word bits 8..0. `wr_valid` is high for exactly one system clock cycle per committed word.
- R2: When `mode_3w` is 0, only the 2-wire framing is decoded and chip-select activity produces no write. When `mode_3w` is 1, only the 3-wire framing is decoded and start conditions produce no write and no acknowledge.
- R3: In 3-wire framing, one data bit is taken MSB first on each rising serial clock edge while chip-select is low. A rising chip-select commits the last 16 bits taken.
- R4: In 3-wire framing, a rising chip-select after fewer than 16 bits since chip-select fell produces no write.
- R5: In 2-wire framing, a falling data line while the clock is high is a start condition. The next 8 bits, MSB first on rising clock edges, form the device address (7 bits) followed by a direction bit.
- R6: If the device address equals parameter `DEV_ADDR` and the direction bit is 0, `dat_pull_low` goes high after the clock falls at the end of the eighth bit. It stays high through the following clock pulse and is released after that pulse falls.
- R7: If the device address differs or the direction bit is 1, there is no acknowledge and no write until the next start condition.
- R8: After an acknowledged address, the block takes two bytes: the first holds word bits 15..8 and the second holds bits 7..0. Each byte is acknowledged, and the write strobe fires when the clock falls at the end of the second data acknowledge.
- R9: A stop condition (data rising while the clock is high) or a repeated start before the second data acknowledge discards the partial word. A repeated start begins a fresh address phase.
- R10: `dat_pull_low` is asserted only in 2-wire framing.
- R11: Two write strobes are never on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_3w | input | 1 | Framing select: 1 = latched 3-wire, 0 = 2-wire (default when tied low) |
| ser_clk | input | 1 | Serial clock from host |
| ser_dat | input | 1 | Serial data line (bus level in 2-wire framing) |
| ser_cs | input | 1 | Chip-select strobe, active low, used in 3-wire framing |
| dat_pull_low | output | 1 | Open-drain enable: 1 pulls the data line low for an acknowledge |
| wr_valid | output | 1 | One-cycle register write strobe |
| wr_addr | output | 7 | Register address of the write |
| wr_data | output | 9 | Value written |

## Verification
The assertions assume that `mode_3w` only changes while the serial lines are idle. They also assume that the serial clock and data never change within the same synchronized sample, except at genuine start and stop conditions, and that chip-select never rises in the same sample as a clock edge. The stimulus holds every line level for eight system cycles between changes. This keeps each transition at least three cycles apart after synchronization. The bench switches the framing only between transfers, with the lines parked at the idle level of the new framing.

// File: rtl/ctlp_pkg.sv
package ctlp_pkg;
  localparam int REG_AW  = 7;
  localparam int REG_DW  = 9;
  localparam int WORD_W  = REG_AW + REG_DW;
  localparam int BYTE_W  = 8;

  typedef struct packed {
    logic [REG_AW-1:0] addr;
    logic [REG_DW-1:0] data;
  } ctl_word_t;

  typedef enum logic [1:0] {
    TW_IDLE,
    TW_RECV,
    TW_PREACK,
    TW_ACK
  } tw_state_t;
endpackage

// File: rtl/ctlp_line_sync.sv
module ctlp_line_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic lvl,
  output logic rise,
  output logic fall
);
  // pipe[0] is the newest sample, pipe[STAGES-1] the synchronized level,
  // pipe[STAGES] the level one cycle earlier
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {(STAGES+1){RST_VAL}};
    else        pipe <= {pipe[STAGES-1:0], d};
  end

  assign lvl  = pipe[STAGES-1];
  assign rise =  pipe[STAGES-1] & ~pipe[STAGES];
  assign fall = ~pipe[STAGES-1] &  pipe[STAGES];
endmodule

// File: rtl/ctlp_latch_rx.sv
module ctlp_latch_rx
  import ctlp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      sck_rise,
  input  logic      dat_lvl,
  input  logic      cs_lvl,
  input  logic      cs_rise,
  input  logic      cs_fall,
  output logic      word_valid,
  output ctl_word_t word
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg      <= '0;
      cnt        <= '0;
      word_valid <= 1'b0;
      word       <= '0;
    end else if (!en) begin
      cnt        <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      if (cs_rise) begin
        if (cnt == FULL) begin
          word_valid <= 1'b1;
          word       <= ctl_word_t'(shreg);
        end
        cnt <= '0;
      end else if (cs_fall) begin
        cnt <= '0;
      end else if (sck_rise && !cs_lvl) begin
        shreg <= {shreg[WORD_W-2:0], dat_lvl};
        if (cnt != FULL) cnt <= cnt + 1'b1;
      end
    end
  end

  // R3: a commit only follows a chip-select rising edge
  assert_commit_on_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(cs_rise));
endmodule

// File: rtl/ctlp_bus_rx.sv
module ctlp_bus_rx
  import ctlp_pkg::*;
#(
  parameter logic [REG_AW-1:0] DEV_ADDR = 7'h1A
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      sck_lvl,
  input  logic      sck_rise,
  input  logic      sck_fall,
  input  logic      dat_lvl,
  input  logic      dat_rise,
  input  logic      dat_fall,
  output logic      pull,
  output logic      word_valid,
  output ctl_word_t word
);
  tw_state_t         st;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] hi_byte;
  logic [2:0]        bitn;
  logic [1:0]        bidx;
  logic              start_c, stop_c;
  logic [BYTE_W-1:0] next_sh;

  assign start_c = sck_lvl & dat_fall;
  assign stop_c  = sck_lvl & dat_rise;
  assign next_sh = {shreg[BYTE_W-2:0], dat_lvl};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= TW_IDLE;
      shreg      <= '0;
      hi_byte    <= '0;
      bitn       <= '0;
      bidx       <= '0;
      pull       <= 1'b0;
      word_valid <= 1'b0;
      word       <= '0;
    end else if (!en) begin
      st         <= TW_IDLE;
      pull       <= 1'b0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      if (start_c) begin
        st   <= TW_RECV;
        bitn <= '0;
        bidx <= '0;
        pull <= 1'b0;
      end else if (stop_c) begin
        st   <= TW_IDLE;
        pull <= 1'b0;
      end else begin
        case (st)
          TW_RECV: if (sck_rise) begin
            shreg <= next_sh;
            bitn  <= bitn + 1'b1;
            if (bitn == 3'd7) begin
              if (bidx == 2'd0 && next_sh != {DEV_ADDR, 1'b0}) st <= TW_IDLE;
              else                                              st <= TW_PREACK;
            end
          end
          TW_PREACK: if (sck_fall) begin
            pull <= 1'b1;
            st   <= TW_ACK;
            if (bidx == 2'd1) hi_byte <= shreg;
          end
          TW_ACK: if (sck_fall) begin
            pull <= 1'b0;
            if (bidx == 2'd2) begin
              word_valid <= 1'b1;
              word       <= ctl_word_t'({hi_byte, shreg});
              st         <= TW_IDLE;
            end else begin
              bidx <= bidx + 1'b1;
              st   <= TW_RECV;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R6: the acknowledge pull starts while the clock is low
  assert_ack_low_clock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull) |-> !sck_lvl);

  // R8: a 2-wire write ends an acknowledge pulse
  assert_write_after_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(pull));
endmodule

// File: rtl/ctlport_slave.sv
module ctlport_slave
  import ctlp_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h1A,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_3w,
  input  logic       ser_clk,
  input  logic       ser_dat,
  input  logic       ser_cs,
  output logic       dat_pull_low,
  output logic       wr_valid,
  output logic [6:0] wr_addr,
  output logic [8:0] wr_data
);
  localparam int NLINES = 3;  // 0: clock, 1: data, 2: chip-select

  logic [NLINES-1:0] raw, lvl, rise, fall;
  assign raw = {ser_cs, ser_dat, ser_clk};

  for (genvar g = 0; g < NLINES; g++) begin : g_sync
    ctlp_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw[g]),
      .lvl(lvl[g]), .rise(rise[g]), .fall(fall[g])
    );
  end

  logic      lr_valid, br_valid, br_pull;
  ctl_word_t lr_word, br_word, out_word;

  ctlp_latch_rx u_latch (
    .clk(clk), .rst_n(rst_n), .en(mode_3w),
    .sck_rise(rise[0]), .dat_lvl(lvl[1]),
    .cs_lvl(lvl[2]), .cs_rise(rise[2]), .cs_fall(fall[2]),
    .word_valid(lr_valid), .word(lr_word)
  );

  ctlp_bus_rx #(.DEV_ADDR(DEV_ADDR)) u_bus (
    .clk(clk), .rst_n(rst_n), .en(!mode_3w),
    .sck_lvl(lvl[0]), .sck_rise(rise[0]), .sck_fall(fall[0]),
    .dat_lvl(lvl[1]), .dat_rise(rise[1]), .dat_fall(fall[1]),
    .pull(br_pull), .word_valid(br_valid), .word(br_word)
  );

  assign wr_valid     = mode_3w ? lr_valid : br_valid;
  assign out_word     = mode_3w ? lr_word  : br_word;
  assign wr_addr      = out_word.addr;
  assign wr_data      = out_word.data;
  assign dat_pull_low = br_pull;

  // R11: strobes are isolated
  assert_single_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  // R10: no acknowledge pull in 3-wire framing
  assert_pull_only_2w_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dat_pull_low |-> !mode_3w);
endmodule

// File: tb/sim_ctlport_slave.sv
`timescale 1ns/1ps
module sim_ctlport_slave;
  localparam logic [6:0] DEV = 7'h1A;
  localparam int H = 8;

  logic clk = 0, rst_n = 0, mode_3w = 0;
  logic sck = 1, h_sda = 1, cs = 1;
  logic pull, wr_valid;
  logic [6:0] wr_addr;
  logic [8:0] wr_data;
  logic bus_dat;

  assign bus_dat = mode_3w ? h_sda : (h_sda & ~pull);

  always #5 clk = ~clk;

  ctlport_slave #(.DEV_ADDR(DEV)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_3w(mode_3w),
    .ser_clk(sck), .ser_dat(bus_dat), .ser_cs(cs),
    .dat_pull_low(pull), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int n_chk = 0, n_fail = 0, nwr = 0, pull3 = 0, back2back = 0;
  logic [6:0] cap_a;
  logic [8:0] cap_d;
  logic prev_v = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (wr_valid) begin nwr++; cap_a = wr_addr; cap_d = wr_data; end
    if (wr_valid && prev_v) back2back++;
    prev_v = wr_valid;
    if (pull && mode_3w) pull3++;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
  endtask

  // ---- 3-wire host ----
  task automatic sw_send(input logic [31:0] bits, input int n);
    cs = 0; settle(H);
    for (int i = n - 1; i >= 0; i--) begin
      h_sda = bits[i]; settle(H);
      sck = 1; settle(H);
      sck = 0;
    end
    settle(H); cs = 1; settle(3 * H);
  endtask

  // ---- 2-wire host ----
  task automatic tw_start();
    h_sda = 1; settle(H); sck = 1; settle(H);
    h_sda = 0; settle(H); sck = 0; settle(H);
  endtask
  task automatic tw_stop();
    h_sda = 0; settle(H); sck = 1; settle(H); h_sda = 1; settle(H);
  endtask
  task automatic tw_bit(input logic b);
    h_sda = b; settle(H); sck = 1; settle(H); sck = 0; settle(H);
  endtask
  task automatic tw_ack(output bit got);
    h_sda = 1; settle(H); sck = 1; settle(H / 2 - 1);
    @(negedge clk); got = (bus_dat == 1'b0);
    settle(H / 2); sck = 0; settle(H);
  endtask
  task automatic tw_byte(input logic [7:0] b, output bit got);
    for (int i = 7; i >= 0; i--) tw_bit(b[i]);
    tw_ack(got);
  endtask

  task automatic go_mode(input logic m);
    settle(H);
    mode_3w = m;
    if (m) begin cs = 1; sck = 0; h_sda = 0; end
    else   begin cs = 1; sck = 1; h_sda = 1; end
    settle(3 * H);
  endtask

  // ---- scenarios ----
  task automatic t_reset();
    @(negedge clk);
    check(wr_valid == 0, "R11 reset strobe", wr_valid, 0);
    check(pull == 0, "R10 reset pull", pull, 0);
  endtask

  task automatic t_3w_word(input logic [15:0] w);
    int n0 = nwr;
    sw_send({16'h0, w}, 16);
    check(nwr == n0 + 1, "R3 3-wire commit count", nwr - n0, 1);
    check(cap_a == w[15:9], "R1 address field", cap_a, w[15:9]);
    check(cap_d == w[8:0], "R1 data field", cap_d, w[8:0]);
  endtask

  task automatic t_3w_short();
    int n0 = nwr;
    sw_send(32'h0ABC, 12);
    check(nwr == n0, "R4 short frame dropped", nwr - n0, 0);
  endtask

  task automatic t_3w_long();
    int n0 = nwr;
    sw_send(32'h000F_1234, 20);
    check(nwr == n0 + 1, "R3 long frame commit", nwr - n0, 1);
    check({cap_a, cap_d} == 16'h1234, "R3 last 16 bits kept", {cap_a, cap_d}, 16'h1234);
  endtask

  task automatic t_3w_in_2w();
    int n0 = nwr;
    cs = 1; sck = 0; settle(H);
    sw_send({16'h0, 16'hFFFF}, 16);
    sck = 1; h_sda = 1; settle(2 * H);
    check(nwr == n0, "R2 3-wire ignored in 2-wire mode", nwr - n0, 0);
  endtask

  task automatic t_2w_write(input logic [15:0] w);
    int n0 = nwr;
    bit a0, a1, a2;
    tw_start();
    tw_byte({DEV, 1'b0}, a0);
    tw_byte(w[15:8], a1);
    check(nwr == n0, "R8 no write before second byte", nwr - n0, 0);
    tw_byte(w[7:0], a2);
    settle(2);
    check(nwr == n0 + 1, "R8 write after second ack", nwr - n0, 1);
    tw_stop();
    check(a0, "R6 address ack", a0, 1);
    check(a1 && a2, "R8 data acks", {a1, a2}, 2'b11);
    check({cap_a, cap_d} == w, "R1 R5 2-wire word", {cap_a, cap_d}, w);
  endtask

  task automatic t_2w_reject(input logic [6:0] dev, input logic rw, input string tag);
    int n0 = nwr;
    bit a0, a1, a2;
    tw_start();
    tw_byte({dev, rw}, a0);
    tw_byte(8'h5A, a1);
    tw_byte(8'hC3, a2);
    tw_stop();
    check(!a0 && !a1 && !a2, tag, {a0, a1, a2}, 0);
    check(nwr == n0, "R7 no write after reject", nwr - n0, 0);
  endtask

  task automatic t_2w_abort();
    int n0 = nwr;
    bit a;
    tw_start();
    tw_byte({DEV, 1'b0}, a);
    tw_byte(8'h77, a);
    for (int i = 0; i < 4; i++) tw_bit(1'b1);
    tw_stop();
    settle(2 * H);
    check(nwr == n0, "R9 stop aborts word", nwr - n0, 0);
    tw_start();
    tw_byte({DEV, 1'b0}, a);
    tw_byte(8'h11, a);
    for (int i = 0; i < 3; i++) tw_bit(1'b0);
    tw_start();
    check(nwr == n0, "R9 repeated start aborts word", nwr - n0, 0);
    tw_byte({DEV, 1'b0}, a);
    check(a, "R9 address ack after repeated start", a, 1);
    tw_byte(8'h9C, a);
    tw_byte(8'h4E, a);
    tw_stop();
    check(nwr == n0 + 1 && {cap_a, cap_d} == 16'h9C4E, "R9 fresh word after restart",
          {cap_a, cap_d}, 16'h9C4E);
  endtask

  task automatic t_2w_in_3w();
    int n0 = nwr;
    bit a;
    sck = 1; h_sda = 1; settle(2 * H);
    tw_start();
    tw_byte({DEV, 1'b0}, a);
    tw_byte(8'h12, a);
    tw_byte(8'h34, a);
    tw_stop();
    check(nwr == n0, "R2 2-wire ignored in 3-wire mode", nwr - n0, 0);
    check(pull3 == 0, "R10 no pull in 3-wire mode", pull3, 0);
    sck = 0; settle(2 * H);
  endtask

  initial begin
    settle(4);
    rst_n = 1;
    settle(4);
    t_reset();
    go_mode(1);
    t_3w_word(16'hB5A3);
    t_3w_word(16'h0001);
    t_3w_short();
    t_3w_long();
    t_2w_in_3w();
    go_mode(0);
    t_2w_write(16'hA5F0);
    t_2w_write(16'h0301);
    t_2w_reject(DEV ^ 7'h01, 1'b0, "R7 wrong address not acked");
    t_2w_reject(DEV, 1'b1, "R7 read request not acked");
    t_2w_abort();
    t_3w_in_2w();
    check(back2back == 0, "R11 isolated strobes", back2back, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule